// File: doc/BRIEF.md
# Overload Guard for a Three-Phase PWM Driver

This block supervises the overload sense line of a three-phase motor driver. While protection is enabled, it samples the sense line every clock. It accepts an overload only after the line has stayed active for a programmed number of consecutive samples. It then latches a protective state. In that state it forces off a chosen group of the six phase outputs, and it can also hold the PWM counter still. The PWM generator uses the per-phase disable outputs and the counter-stop output as gates.

Three paths lead out of the protective state. The first is a software request, a single-cycle strobe that stands for a register write. The second is the PWM period boundary pulse. The third is the timer-1 event pulse. Each path has its own enable field. When the software path is enabled, it is the only path that is honoured. In every case, the block leaves protection only if the sense line is inactive in the cycle of the return event. If the line is still active, the block stays protected and waits for a later event.

Top module: `ovld_guard`

## Requirements
- R1: While reset is high and in the first cycle after reset, `ovl_state` is 0, `phase_off` is 0 and `cnt_stop` is 0.
- R2: With `cfg_enable` low, the block never enters protection. If `cfg_enable` is low at a clock edge, `ovl_state` is 0 after that edge.
- R3: With `cfg_win` = N (N = 0 is treated as 1), `ovl_state` becomes 1 at the edge where `ovl_in` has been sampled high for the Nth consecutive time, and not before.
- R4: A single low sample of `ovl_in` restarts the consecutive count from zero.
- R5: In protection, `phase_off` follows `cfg_mode`: 00 gives 0; 01 gives all six bits; 10 gives `pwm_phase_mask`; 11 gives the lower group 6'b111000 when `cfg_lower` = 1, or the upper group 6'b000111 when `cfg_lower` = 0. Bits [2:0] are the upper phases and bits [5:3] are the lower phases.
- R6: In protection, `cnt_stop` equals `cfg_stop_cnt`.
- R7: With `cfg_ret_sw` = 1, a `sw_ret_req` strobe returns the block from protection at that edge.
- R8: With `cfg_ret_sw` = 0, a `pwm_sync` pulse returns the block when `cfg_ret_pwm` = 1, and a `tmr_sync` pulse returns it when `cfg_ret_tmr` = 1. A pulse whose enable bit is 0 has no effect.
- R9: With `cfg_ret_sw` = 1, `pwm_sync` and `tmr_sync` pulses do not return the block, even when their own enable bits are set.
- R10: A return event that arrives while `ovl_in` is high leaves the block in protection.
- R11: Outside protection, `phase_off` is 0 and `cnt_stop` is 0, whatever the mode and stop settings are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables overload protection |
| cfg_win | input | WIN_W | Number of consecutive active samples needed to confirm an overload (0 is treated as 1) |
| cfg_mode | input | 2 | Selects which phases are disabled during protection |
| cfg_lower | input | 1 | In mode 11, selects the lower group (1) or the upper group (0) |
| pwm_phase_mask | input | 2*NPH | Phases currently driven by PWM, used in mode 10 |
| cfg_stop_cnt | input | 1 | Stops the PWM counter during protection |
| cfg_ret_sw | input | 1 | Enables the software return path; this path has priority |
| cfg_ret_pwm | input | 1 | Enables return at the PWM period boundary |
| cfg_ret_tmr | input | 1 | Enables return at the timer-1 event |
| sw_ret_req | input | 1 | Software return strobe |
| ovl_in | input | 1 | Overload sense line, active high |
| pwm_sync | input | 1 | PWM period boundary pulse |
| tmr_sync | input | 1 | Timer-1 event pulse |
| ovl_state | output | 1 | High while the block is in the protective state |
| phase_off | output | 2*NPH | Per-phase disable outputs |
| cnt_stop | output | 1 | PWM counter stop |

## Verification
The hardest situation to reach is a return event that arrives while the sense line is still active, combined with a lower-priority sync pulse that arrives while the software path holds priority. The stimulus first places the block in protection. It then keeps `ovl_in` high and fires each return source in turn. Next it sets all three return enables and fires only the sync pulses. Finally it lowers the sense line and issues the software strobe. Before that, the window logic is driven to one sample short of the programmed count, broken by a single low sample, and then completed.

// File: rtl/ovld_pkg.sv
package ovld_pkg;

    typedef enum logic [1:0] {
        OFF_NONE  = 2'b00,
        OFF_ALL   = 2'b01,
        OFF_PWM   = 2'b10,
        OFF_GROUP = 2'b11
    } off_mode_e;

    typedef struct packed {
        logic sw;
        logic pwm;
        logic tmr;
    } ret_src_t;

    // Effective window length: a programmed zero counts as one sample.
    function automatic logic [15:0] win_eff(input logic [15:0] w);
        return (w == 16'd0) ? 16'd1 : w;
    endfunction

endpackage

// File: rtl/ovld_sampler.sv
module ovld_sampler #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ovl_in,
    input  logic [WIN_W-1:0] win,
    output logic             trip
);
    import ovld_pkg::*;

    localparam logic [WIN_W-1:0] RUN_MAX = {WIN_W{1'b1}};

    logic [WIN_W-1:0] run;
    logic [WIN_W-1:0] need;

    always_comb begin
        need = WIN_W'(win_eff(16'(win)));
        trip = ovl_in && !clear && (run >= need - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || !ovl_in) begin
            run <= '0;
        end else if (run != RUN_MAX) begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/ovld_return_sel.sv
module ovld_return_sel (
    input  ovld_pkg::ret_src_t en,
    input  logic               sw_ret_req,
    input  logic               pwm_sync,
    input  logic               tmr_sync,
    output logic               ret_evt
);
    always_comb begin
        if (en.sw) begin
            ret_evt = sw_ret_req;
        end else begin
            ret_evt = (en.pwm && pwm_sync) || (en.tmr && tmr_sync);
        end
    end
endmodule

// File: rtl/ovld_phase_mask.sv
module ovld_phase_mask #(
    parameter int NPH = 3
) (
    input  logic                   active,
    input  ovld_pkg::off_mode_e    mode,
    input  logic                   lower,
    input  logic [2*NPH-1:0]       pwm_mask,
    output logic [2*NPH-1:0]       off
);
    import ovld_pkg::*;

    for (genvar g = 0; g < 2 * NPH; g++) begin : g_ph
        localparam bit IS_LOWER = (g >= NPH);
        always_comb begin
            unique case (mode)
                OFF_NONE:  off[g] = 1'b0;
                OFF_ALL:   off[g] = active;
                OFF_PWM:   off[g] = active && pwm_mask[g];
                OFF_GROUP: off[g] = active && (lower == IS_LOWER);
                default:   off[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ovld_guard.sv
module ovld_guard #(
    parameter int WIN_W = 8,
    parameter int NPH   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic [WIN_W-1:0] cfg_win,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_lower,
    input  logic [2*NPH-1:0] pwm_phase_mask,
    input  logic             cfg_stop_cnt,
    input  logic             cfg_ret_sw,
    input  logic             cfg_ret_pwm,
    input  logic             cfg_ret_tmr,
    input  logic             sw_ret_req,
    input  logic             ovl_in,
    input  logic             pwm_sync,
    input  logic             tmr_sync,
    output logic             ovl_state,
    output logic [2*NPH-1:0] phase_off,
    output logic             cnt_stop
);
    import ovld_pkg::*;

    logic     prot_q;
    logic     trip;
    logic     ret_evt;
    ret_src_t ret_en;

    assign ret_en = '{sw: cfg_ret_sw, pwm: cfg_ret_pwm, tmr: cfg_ret_tmr};

    ovld_sampler #(.WIN_W(WIN_W)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .clear  (prot_q || !cfg_enable),
        .ovl_in (ovl_in),
        .win    (cfg_win),
        .trip   (trip)
    );

    ovld_return_sel u_ret (
        .en         (ret_en),
        .sw_ret_req (sw_ret_req),
        .pwm_sync   (pwm_sync),
        .tmr_sync   (tmr_sync),
        .ret_evt    (ret_evt)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg_enable) begin
            prot_q <= 1'b0;
        end else if (!prot_q) begin
            prot_q <= trip;
        end else if (ret_evt && !ovl_in) begin
            prot_q <= 1'b0;
        end
    end

    ovld_phase_mask #(.NPH(NPH)) u_mask (
        .active   (prot_q),
        .mode     (off_mode_e'(cfg_mode)),
        .lower    (cfg_lower),
        .pwm_mask (pwm_phase_mask),
        .off      (phase_off)
    );

    assign ovl_state = prot_q;
    assign cnt_stop  = prot_q && cfg_stop_cnt;

endmodule

// File: rtl/ovld_guard_chk.sv
module ovld_guard_chk #(
    parameter int WIN_W = 8,
    parameter int NPH   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_ret_sw,
    input logic             sw_ret_req,
    input logic             ovl_in,
    input logic             ovl_state,
    input logic [2*NPH-1:0] phase_off,
    input logic             cnt_stop
);
    // R2: a low enable clears protection at the next edge
    a_r2_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !ovl_state);

    // R3: protection is entered only from an enabled block with the line active
    a_r3_entry_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovl_state) |-> ($past(ovl_in) && $past(cfg_enable)));

    // R10: leaving protection with enable still high needs an inactive line
    a_r10_return_idle: assert property (@(posedge clk) disable iff (rst)
        ($fell(ovl_state) && $past(cfg_enable)) |-> !$past(ovl_in));

    // R9: with the software path selected, nothing but its strobe ends protection
    a_r9_sw_priority: assert property (@(posedge clk) disable iff (rst)
        (ovl_state && cfg_enable && cfg_ret_sw && !sw_ret_req) |=> ovl_state);

    // R11: outputs are quiet outside protection
    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !ovl_state |-> (phase_off == '0 && !cnt_stop));
endmodule

bind ovld_guard ovld_guard_chk #(.WIN_W(WIN_W), .NPH(NPH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .cfg_ret_sw (cfg_ret_sw),
    .sw_ret_req (sw_ret_req),
    .ovl_in     (ovl_in),
    .ovl_state  (ovl_state),
    .phase_off  (phase_off),
    .cnt_stop   (cnt_stop)
);

// File: tb/ovld_guard_test.sv
module ovld_guard_test;
    localparam int WIN_W = 8;
    localparam int NPH   = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_enable = 1'b0;
    logic [WIN_W-1:0] cfg_win = '0;
    logic [1:0]       cfg_mode = 2'b00;
    logic             cfg_lower = 1'b0;
    logic [5:0]       pwm_phase_mask = 6'b010101;
    logic             cfg_stop_cnt = 1'b0;
    logic             cfg_ret_sw = 1'b0;
    logic             cfg_ret_pwm = 1'b0;
    logic             cfg_ret_tmr = 1'b0;
    logic             sw_ret_req = 1'b0;
    logic             ovl_in = 1'b0;
    logic             pwm_sync = 1'b0;
    logic             tmr_sync = 1'b0;
    logic             ovl_state;
    logic [5:0]       phase_off;
    logic             cnt_stop;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ovld_guard #(.WIN_W(WIN_W), .NPH(NPH)) uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic restart();
        cfg_enable = 1'b0; ovl_in = 1'b0;
        cfg_ret_sw = 1'b0; cfg_ret_pwm = 1'b0; cfg_ret_tmr = 1'b0;
        step();
        cfg_enable = 1'b1;
    endtask

    task automatic trip_now();
        cfg_win = 8'd1; ovl_in = 1'b1;
        step();
        ovl_in = 1'b0;
    endtask

    task automatic t_reset();
        ovl_in = 1'b1; cfg_enable = 1'b1; cfg_mode = 2'b01; cfg_stop_cnt = 1'b1;
        repeat (3) step();
        chk("R1 state in reset", 32'(ovl_state), 0);
        chk("R1 phase_off in reset", 32'(phase_off), 0);
        chk("R1 cnt_stop in reset", 32'(cnt_stop), 0);
        ovl_in = 1'b0;
        rst = 1'b0;
        step();
        chk("R1 state after reset", 32'(ovl_state), 0);
    endtask

    task automatic t_window();
        restart();
        cfg_win = 8'd4; cfg_mode = 2'b01;
        ovl_in = 1'b1;
        repeat (3) step();
        chk("R3 before window ends", 32'(ovl_state), 0);
        ovl_in = 1'b0; step();
        ovl_in = 1'b1;
        repeat (3) step();
        chk("R4 window restarted", 32'(ovl_state), 0);
        step();
        chk("R3 confirmed at 4th sample", 32'(ovl_state), 1);
        chk("R5 mode all", 32'(phase_off), 32'h3F);
        ovl_in = 1'b0; cfg_ret_sw = 1'b1;
        sw_ret_req = 1'b1; step(); sw_ret_req = 1'b0;
        chk("R7 software return", 32'(ovl_state), 0);
        restart();
        cfg_win = 8'd0; ovl_in = 1'b1; step(); ovl_in = 1'b0;
        chk("R3 zero window acts as one", 32'(ovl_state), 1);
    endtask

    task automatic t_modes();
        restart();
        trip_now();
        cfg_mode = 2'b00; #1;
        chk("R5 mode none", 32'(phase_off), 0);
        cfg_mode = 2'b10; #1;
        chk("R5 mode pwm phases", 32'(phase_off), 32'h15);
        cfg_mode = 2'b11; cfg_lower = 1'b0; #1;
        chk("R5 mode upper group", 32'(phase_off), 32'h07);
        cfg_lower = 1'b1; #1;
        chk("R5 mode lower group", 32'(phase_off), 32'h38);
        cfg_stop_cnt = 1'b1; #1;
        chk("R6 counter stopped", 32'(cnt_stop), 1);
        cfg_stop_cnt = 1'b0; #1;
        chk("R6 counter running", 32'(cnt_stop), 0);
        cfg_mode = 2'b01; cfg_stop_cnt = 1'b1;
        cfg_ret_sw = 1'b1; sw_ret_req = 1'b1; step(); sw_ret_req = 1'b0;
        chk("R11 phase_off idle", 32'(phase_off), 0);
        chk("R11 cnt_stop idle", 32'(cnt_stop), 0);
    endtask

    task automatic t_sync_return();
        restart();
        cfg_ret_pwm = 1'b1;
        trip_now();
        tmr_sync = 1'b1; step(); tmr_sync = 1'b0;
        chk("R8 timer pulse ignored when not enabled", 32'(ovl_state), 1);
        ovl_in = 1'b1;
        pwm_sync = 1'b1; step(); pwm_sync = 1'b0;
        chk("R10 pwm return blocked by active line", 32'(ovl_state), 1);
        ovl_in = 1'b0;
        pwm_sync = 1'b1; step(); pwm_sync = 1'b0;
        chk("R8 pwm sync return", 32'(ovl_state), 0);
        cfg_ret_pwm = 1'b0; cfg_ret_tmr = 1'b1;
        trip_now();
        pwm_sync = 1'b1; step(); pwm_sync = 1'b0;
        chk("R8 pwm pulse ignored when not enabled", 32'(ovl_state), 1);
        tmr_sync = 1'b1; step(); tmr_sync = 1'b0;
        chk("R8 timer sync return", 32'(ovl_state), 0);
    endtask

    task automatic t_priority();
        restart();
        cfg_ret_sw = 1'b1; cfg_ret_pwm = 1'b1; cfg_ret_tmr = 1'b1;
        trip_now();
        pwm_sync = 1'b1; step(); pwm_sync = 1'b0;
        chk("R9 pwm pulse under sw priority", 32'(ovl_state), 1);
        tmr_sync = 1'b1; step(); tmr_sync = 1'b0;
        chk("R9 timer pulse under sw priority", 32'(ovl_state), 1);
        ovl_in = 1'b1; sw_ret_req = 1'b1; step(); sw_ret_req = 1'b0;
        chk("R10 sw return blocked by active line", 32'(ovl_state), 1);
        ovl_in = 1'b0; sw_ret_req = 1'b1; step(); sw_ret_req = 1'b0;
        chk("R7 sw return after line clears", 32'(ovl_state), 0);
    endtask

    task automatic t_enable();
        restart();
        cfg_enable = 1'b0; cfg_win = 8'd1; ovl_in = 1'b1;
        repeat (5) step();
        chk("R2 no entry while disabled", 32'(ovl_state), 0);
        ovl_in = 1'b0;
        cfg_enable = 1'b1;
        trip_now();
        chk("R2 entry once enabled", 32'(ovl_state), 1);
        cfg_enable = 1'b0; step();
        chk("R2 disable clears state", 32'(ovl_state), 0);
    endtask

    initial begin
        t_reset();
        t_window();
        t_modes();
        t_sync_return();
        t_priority();
        t_enable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule